// File: doc/BRIEF.md
# Transmit Context Descriptor Processor

This block accepts transmit context descriptors from the descriptor fetch logic over a valid/ready handshake. It decodes the command byte of each descriptor and, when the descriptor is marked as extended, overwrites one of two offload context banks in the same cycle. One bank holds the TCP segmentation context and the other holds the plain checksum offload context. The packet engine downstream reads the stored fields of both banks directly: whether a context has been loaded, the L4 type, the IP version and a data field (header length or frame size, for example). The block also raises a flag when the segmentation context describes a generic block send.

When a descriptor asks for status reporting, the block spends one extra cycle issuing a status write-back word. In that word only the descriptor-done bit carries meaning. While it does so it holds off the next descriptor. A small tracker watches the data descriptors that the packet engine consumes and keeps one packet-open flag per bank. If a bank is overwritten while its packet is still open, a sticky hazard bit for that bank is set.

The control is a two-state machine. `ST_IDLE` accepts descriptors, with `desc_ready` high. `ST_REPORT` drives the write-back for one cycle, with `desc_ready` low. The transition `ST_IDLE -> ST_REPORT` is taken on an accepted extended descriptor with report-status set. The transition `ST_REPORT -> ST_IDLE` is always taken on the next edge. In every other case the machine stays in `ST_IDLE`.

Top module: `txctx_proc`

## Requirements
- R1: Command byte bit positions are: bit 0 = TCP (1 = TCP, 0 = UDP/other), bit 1 = IP version (1 = IPv4, 0 = IPv6), bit 2 = segmentation enable, bit 3 = report status, bit 5 = extension. Bits 4, 6 and 7 are reserved and have no effect on any output.
- R2: A descriptor accepted with the extension bit at 0 changes no context output and produces no write-back.
- R3: An accepted extended descriptor loads bank 1 (segmentation) when segmentation enable is 1 and bank 0 (checksum) when it is 0. The other bank keeps its contents.
- R4: The loaded bank's `ctx_tcp`, `ctx_ipv4` and data output take the descriptor's values, and its `ctx_valid` goes to 1. All of these change on the clock edge of the handshake and at no other time.
- R5: `seg_blk_send` is 1 exactly when bank 1 is valid and its TCP and IPv4 flags are both 0.
- R6: An accepted extended descriptor with report status set makes `wb_valid` high for exactly the one cycle after the handshake edge, with `wb_status` = 4'b0001 (bit 0 = done, all other bits 0). Otherwise `wb_valid` stays 0.
- R7: `desc_ready` is 0 while `wb_valid` is 1. A descriptor held valid during that cycle is not accepted until the following cycle.
- R8: `pkt_open[b]` is set by a data descriptor for bank b with `pkt_eop` = 0 and cleared by one with `pkt_eop` = 1.
- R9: An update of bank b while `pkt_open[b]` is 1 sets `hazard[b]`. The bit then stays set until reset.
- R10: After reset `desc_ready` = 1 and all context, write-back, open and hazard outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Descriptor can be taken this cycle |
| desc_cmd | input | 8 | Command byte |
| desc_data | input | CTX_W | Context data field |
| pkt_valid | input | 1 | Data descriptor consumed by packet engine |
| pkt_seg | input | 1 | Data descriptor uses bank 1 (else bank 0) |
| pkt_eop | input | 1 | Data descriptor ends its packet |
| ctx_valid | output | 2 | Bank has been loaded, index = bank |
| ctx_tcp | output | 2 | Stored TCP flag per bank |
| ctx_ipv4 | output | 2 | Stored IPv4 flag per bank |
| seg_data | output | CTX_W | Data field of bank 1 |
| csum_data | output | CTX_W | Data field of bank 0 |
| seg_blk_send | output | 1 | Segmentation context is generic block send |
| wb_valid | output | 1 | Status write-back strobe |
| wb_status | output | 4 | Status word |
| pkt_open | output | 2 | Packet in progress per bank |
| hazard | output | 2 | Sticky unsafe-update flag per bank |

## Verification
The bench builds the block with `CTX_W` = 4, which keeps the data field small. It sweeps all 256 command byte values from reset. That sweep reaches every combination of extension, report, segmentation, IP and L4 flags together with every pattern of the reserved bits. It also checks each bank's stored fields and the write-back after every descriptor. Directed sequences then hold a descriptor across the report cycle and walk both packet-open flags through update-while-open cases, so the per-bank hazard bits can be observed one at a time.

// File: rtl/txctx_pkg.sv
package txctx_pkg;
    localparam int CMD_W   = 8;
    localparam int STAT_W  = 4;
    localparam int NBANK   = 2;
    localparam int BIT_TCP = 0;
    localparam int BIT_IP4 = 1;
    localparam int BIT_TSE = 2;
    localparam int BIT_RS  = 3;
    localparam int BIT_EXT = 5;
    localparam int BANK_CSUM = 0;
    localparam int BANK_SEG  = 1;

    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_REPORT = 1'b1
    } st_t;

    typedef struct packed {
        logic ext;
        logic rs;
        logic tse;
        logic ip4;
        logic tcp;
    } cmd_t;
endpackage

// File: rtl/txctx_cmd_decode.sv
module txctx_cmd_decode
    import txctx_pkg::*;
(
    input  logic [CMD_W-1:0] cmd,
    output cmd_t             fields
);
    always_comb begin
        fields.ext = cmd[BIT_EXT];
        fields.rs  = cmd[BIT_RS];
        fields.tse = cmd[BIT_TSE];
        fields.ip4 = cmd[BIT_IP4];
        fields.tcp = cmd[BIT_TCP];
    end
endmodule

// File: rtl/txctx_bank.sv
module txctx_bank #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          tcp_i,
    input  logic          ip4_i,
    input  logic [DW-1:0] data_i,
    output logic          valid_o,
    output logic          tcp_o,
    output logic          ip4_o,
    output logic [DW-1:0] data_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            tcp_o   <= 1'b0;
            ip4_o   <= 1'b0;
            data_o  <= '0;
        end else if (load) begin
            valid_o <= 1'b1;
            tcp_o   <= tcp_i;
            ip4_o   <= ip4_i;
            data_o  <= data_i;
        end
    end

    // R4
    bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(data_o) && $stable(tcp_o) && $stable(ip4_o) && $stable(valid_o)));

    // R4
    bank_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (valid_o && data_o == $past(data_i) && tcp_o == $past(tcp_i)));
endmodule

// File: rtl/txctx_pkt_track.sv
module txctx_pkt_track (
    input  logic clk,
    input  logic rst_n,
    input  logic pkt_hit,
    input  logic pkt_eop,
    input  logic ctx_upd,
    output logic open_o,
    output logic hazard_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            open_o <= 1'b0;
        end else if (pkt_hit) begin
            open_o <= !pkt_eop;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hazard_o <= 1'b0;
        end else if (ctx_upd && open_o) begin
            hazard_o <= 1'b1;
        end
    end

    // R9
    hazard_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hazard_o |=> hazard_o);

    // R8
    open_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_hit && pkt_eop) |=> !open_o);

    // R9
    hazard_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctx_upd && open_o) |=> hazard_o);
endmodule

// File: rtl/txctx_proc.sv
module txctx_proc
    import txctx_pkg::*;
#(
    parameter int CTX_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               desc_valid,
    output logic               desc_ready,
    input  logic [CMD_W-1:0]   desc_cmd,
    input  logic [CTX_W-1:0]   desc_data,
    input  logic               pkt_valid,
    input  logic               pkt_seg,
    input  logic               pkt_eop,
    output logic [NBANK-1:0]   ctx_valid,
    output logic [NBANK-1:0]   ctx_tcp,
    output logic [NBANK-1:0]   ctx_ipv4,
    output logic [CTX_W-1:0]   seg_data,
    output logic [CTX_W-1:0]   csum_data,
    output logic               seg_blk_send,
    output logic               wb_valid,
    output logic [STAT_W-1:0]  wb_status,
    output logic [NBANK-1:0]   pkt_open,
    output logic [NBANK-1:0]   hazard
);
    localparam logic [STAT_W-1:0] STAT_DONE = STAT_W'(1);

    st_t  state, state_nx;
    cmd_t fld;
    logic accept;
    logic ctx_go;
    logic [NBANK-1:0]  bank_load;
    logic [CTX_W-1:0]  bank_data [NBANK];

    txctx_cmd_decode u_dec (
        .cmd    (desc_cmd),
        .fields (fld)
    );

    assign accept = desc_valid && desc_ready;
    assign ctx_go = accept && fld.ext;

    genvar b;
    generate
        for (b = 0; b < NBANK; b++) begin : g_bank
            assign bank_load[b] = ctx_go && (fld.tse == (b == BANK_SEG));

            txctx_bank #(.DW(CTX_W)) u_bank (
                .clk     (clk),
                .rst_n   (rst_n),
                .load    (bank_load[b]),
                .tcp_i   (fld.tcp),
                .ip4_i   (fld.ip4),
                .data_i  (desc_data),
                .valid_o (ctx_valid[b]),
                .tcp_o   (ctx_tcp[b]),
                .ip4_o   (ctx_ipv4[b]),
                .data_o  (bank_data[b])
            );

            txctx_pkt_track u_trk (
                .clk      (clk),
                .rst_n    (rst_n),
                .pkt_hit  (pkt_valid && (pkt_seg == (b == BANK_SEG))),
                .pkt_eop  (pkt_eop),
                .ctx_upd  (bank_load[b]),
                .open_o   (pkt_open[b]),
                .hazard_o (hazard[b])
            );
        end
    endgenerate

    assign seg_data     = bank_data[BANK_SEG];
    assign csum_data    = bank_data[BANK_CSUM];
    assign seg_blk_send = ctx_valid[BANK_SEG] && !ctx_tcp[BANK_SEG] && !ctx_ipv4[BANK_SEG];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (ctx_go && fld.rs) state_nx = ST_REPORT;
            ST_REPORT: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        desc_ready = 1'b0;
        wb_valid   = 1'b0;
        wb_status  = '0;
        unique case (state)
            ST_IDLE:   desc_ready = 1'b1;
            ST_REPORT: begin
                wb_valid  = 1'b1;
                wb_status = STAT_DONE;
            end
            default: ;
        endcase
    end

    // R6
    wb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |=> !wb_valid);

    // R6
    wb_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && fld.ext && fld.rs) |=> (wb_valid && wb_status == STAT_DONE));

    // R7
    busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> !desc_ready);

    // R2
    noext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !fld.ext) |=> (!wb_valid && $stable(ctx_valid) && $stable(seg_data) && $stable(csum_data)));

    // R3
    one_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(bank_load) <= 1);
endmodule

// File: tb/txctx_proc_bench.sv
module txctx_proc_bench;
    localparam int W = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic desc_valid = 1'b0;
    logic desc_ready;
    logic [7:0] desc_cmd = '0;
    logic [W-1:0] desc_data = '0;
    logic pkt_valid = 1'b0, pkt_seg = 1'b0, pkt_eop = 1'b0;
    logic [1:0] ctx_valid, ctx_tcp, ctx_ipv4, pkt_open, hazard;
    logic [W-1:0] seg_data, csum_data;
    logic seg_blk_send, wb_valid;
    logic [3:0] wb_status;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    logic [1:0] m_valid = '0, m_tcp = '0, m_ip4 = '0;
    logic [W-1:0] m_data [2] = '{default: '0};

    always #2.5 clk = ~clk;

    txctx_proc #(.CTX_W(W)) u_txctx_proc (
        .clk(clk), .rst_n(rst_n),
        .desc_valid(desc_valid), .desc_ready(desc_ready),
        .desc_cmd(desc_cmd), .desc_data(desc_data),
        .pkt_valid(pkt_valid), .pkt_seg(pkt_seg), .pkt_eop(pkt_eop),
        .ctx_valid(ctx_valid), .ctx_tcp(ctx_tcp), .ctx_ipv4(ctx_ipv4),
        .seg_data(seg_data), .csum_data(csum_data), .seg_blk_send(seg_blk_send),
        .wb_valid(wb_valid), .wb_status(wb_status),
        .pkt_open(pkt_open), .hazard(hazard)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model_load(input logic [7:0] c, input logic [W-1:0] d);
        if (c[5]) begin
            int bk = c[2] ? 1 : 0;
            m_valid[bk] = 1'b1;
            m_tcp[bk]   = c[0];
            m_ip4[bk]   = c[1];
            m_data[bk]  = d;
        end
    endtask

    task automatic chk_ctx(input string req);
        chk({req, " valid"}, int'(ctx_valid), int'(m_valid));
        chk({req, " tcp"},   int'(ctx_tcp),   int'(m_tcp));
        chk({req, " ipv4"},  int'(ctx_ipv4),  int'(m_ip4));
        chk({req, " seg_data"},  int'(seg_data),  int'(m_data[1]));
        chk({req, " csum_data"}, int'(csum_data), int'(m_data[0]));
        // R5
        chk("R5 blk_send", int'(seg_blk_send), int'(m_valid[1] && !m_tcp[1] && !m_ip4[1]));
    endtask

    task automatic send(input logic [7:0] c, input logic [W-1:0] d);
        bit rep;
        rep = c[5] && c[3];
        @(negedge clk);
        desc_valid = 1'b1; desc_cmd = c; desc_data = d;
        @(posedge clk);
        @(negedge clk);
        desc_valid = 1'b0;
        model_load(c, d);
        // R1 R2 R3 R4
        chk_ctx("R3 R4 R1 R2");
        // R6
        chk("R6 wb_valid", int'(wb_valid), int'(rep));
        chk("R6 wb_status", int'(wb_status), rep ? 1 : 0);
        // R7
        chk("R7 ready", int'(desc_ready), int'(!rep));
        if (rep) begin
            @(negedge clk);
            chk("R6 wb_drop", int'(wb_valid), 0);
            chk("R7 ready_back", int'(desc_ready), 1);
        end
    endtask

    task automatic pkt(input logic seg, input logic eop);
        @(negedge clk);
        pkt_valid = 1'b1; pkt_seg = seg; pkt_eop = eop;
        @(negedge clk);
        pkt_valid = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10
        chk("R10 ready", int'(desc_ready), 1);
        chk("R10 wb_valid", int'(wb_valid), 0);
        chk("R10 ctx_valid", int'(ctx_valid), 0);
        chk("R10 open", int'(pkt_open), 0);
        chk("R10 hazard", int'(hazard), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk_ctx("R10 post");

        // full command sweep, R1 R2 R3 R4 R5 R6
        for (int i = 0; i < 256; i++) begin
            send(8'(i), W'(i * 3 + 1));
        end
        chk("R9 no_hazard_sweep", int'(hazard), 0);

        // R7: descriptor held through the report cycle
        @(negedge clk);
        desc_valid = 1'b1; desc_cmd = 8'h2c; desc_data = 4'h9;
        @(posedge clk);
        @(negedge clk);
        model_load(8'h2c, 4'h9);
        desc_cmd = 8'h23; desc_data = 4'h6;
        chk("R7 busy_ready", int'(desc_ready), 0);
        chk("R6 busy_wb", int'(wb_valid), 1);
        @(posedge clk);
        @(negedge clk);
        chk("R7 held_not_taken", int'(csum_data), int'(m_data[0]));
        chk("R7 ready_again", int'(desc_ready), 1);
        @(posedge clk);
        @(negedge clk);
        desc_valid = 1'b0;
        model_load(8'h23, 4'h6);
        chk_ctx("R7 held_taken");
        chk("R6 no_rs_wb", int'(wb_valid), 0);

        // R8 R9 tracking
        pkt(1'b0, 1'b1);
        chk("R8 eop_on_closed", int'(pkt_open), 0);
        pkt(1'b1, 1'b0);
        chk("R8 open_seg", int'(pkt_open), 2);
        send(8'h24, 4'h3);
        chk("R9 hazard_seg", int'(hazard), 2);
        pkt(1'b1, 1'b1);
        chk("R8 close_seg", int'(pkt_open), 0);
        send(8'h20, 4'h5);
        chk("R9 closed_csum", int'(hazard), 2);
        pkt(1'b0, 1'b0);
        chk("R8 open_csum", int'(pkt_open), 1);
        send(8'h04, 4'h7);
        chk("R9 noext_no_hazard", int'(hazard), 2);
        send(8'h23, 4'ha);
        chk("R9 hazard_csum", int'(hazard), 3);
        pkt(1'b0, 1'b1);
        chk("R8 close_csum", int'(pkt_open), 0);
        send(8'h2c, 4'h1);
        chk("R9 sticky", int'(hazard), 3);

        finish_run();
    end
endmodule